// File: doc/BRIEF.md
# Lane Bit Matrix with Pass-through and Transpose Modes

This block sits between per-lane block encoders and a ten-lane electrical interface. It re-maps parallel lane data so that each physical optical lane keeps carrying whole blocks. A one-bit module-type input selects one of two modes. In straight mode, ten input lanes are forwarded to ten output lanes unchanged. In transpose mode, four physical input lanes are spread word-wise across all ten output lanes. Each output lane then carries, in turn, one slice from every physical lane.

Storage is two banks used in ping-pong fashion. While one bank is filled row by row from the input, the other bank is emptied column by column towards the output. A single bank-select flag swaps their roles at a period boundary. The mode is sampled once per period, on the period's first accepted input beat. The first output period after a mode change is marked so that downstream logic can discard it.

Both data sides are valid/ready streams. A beat moves when valid and ready are both high at a rising clock edge. Valid and data are not required to wait for ready. The output holds its valid and data for as long as ready is low. The input stalls, with ready low, only when one bank is complete and the other bank has not yet been drained.

Top module: `lane_bit_matrix`

## Requirements
- R1: During and right after reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Mode encoding is 0 for straight mode. In straight mode a period is LANES input beats, and output beat k equals input beat k lane for lane, so LANES output beats are produced per period.
- R3: Mode encoding is 1 for transpose mode. A period is LANES input beats, of which only lanes 0 to PHY_LANES-1 are used; higher lanes are ignored. Output beat r, lane k equals input beat k, lane r. PHY_LANES output beats are produced per period.
- R4: The mode is sampled on the first accepted beat of each period. A change of `module_type_i` during a period has no effect on that period.
- R5: `out_settle` is 1 on every output beat of a period whose mode differs from the mode of the period before it. The mode before the first period is straight mode.
- R6: With `out_ready` held low, exactly 2*LANES beats are accepted (one period in each bank), and `in_ready` is then 0.
- R7: `out_valid` stays 0 until a full period has been written. The first beat of a period becomes valid on the clock edge that accepts that period's last input beat, provided the read bank is idle. `out_valid` is never 1 without a pending period.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold their values into the next cycle.
- R9: Lane j occupies bits [j*WORD_W +: WORD_W] on both data buses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| module_type_i | input | 1 | 0 = straight, 1 = transpose |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat can be accepted |
| in_data | input | LANES*WORD_W | Input lanes |
| out_valid | output | 1 | Output beat offered |
| out_ready | input | 1 | Downstream accepts beat |
| out_data | output | LANES*WORD_W | Output lanes |
| out_settle | output | 1 | Beat belongs to first period after a mode change |

## Verification
The main function is driven with random words in straight mode, in transpose mode, and with the mode toggling both at period boundaries and in the middle of periods. Straight mode exposes any lane swap or beat reorder. Transpose mode separates a correct transpose from an identity mapping and from a mirrored index. Mid-period toggles show whether the mode is sampled on the first beat of the period or later. A long stall with `out_ready` low probes bank capacity and output hold. Random ready and valid gaps exercise the swap conditions when write and read finish in the same cycle.

// File: rtl/bmx_pkg.sv
package bmx_pkg;
  typedef enum logic {
    MODE_STRAIGHT = 1'b0,
    MODE_XPOSE    = 1'b1
  } bmx_mode_e;
endpackage

// File: rtl/bmx_bank.sv
module bmx_bank
  import bmx_pkg::*;
#(
  parameter int LANES     = 10,
  parameter int PHY_LANES = 4,
  parameter int WORD_W    = 16,
  localparam int DW = LANES * WORD_W,
  localparam int CW = $clog2(LANES)
) (
  input  logic          clk,
  input  logic          we,
  input  bmx_mode_e     wmode,
  input  logic [CW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [CW-1:0] ridx,
  output logic [DW-1:0] rdata
);
  // word store indexed [column = output lane][slot = output beat]
  logic [WORD_W-1:0] mem [LANES][LANES];

  always_ff @(posedge clk) begin
    if (we) begin
      if (wmode == MODE_STRAIGHT) begin
        for (int c = 0; c < LANES; c++) mem[c][widx] <= wdata[c*WORD_W +: WORD_W];
      end else begin
        for (int r = 0; r < PHY_LANES; r++) mem[widx][r] <= wdata[r*WORD_W +: WORD_W];
      end
    end
  end

  always_comb begin
    for (int j = 0; j < LANES; j++) rdata[j*WORD_W +: WORD_W] = mem[j][ridx];
  end
endmodule

// File: rtl/bmx_pingpong_ctrl.sv
module bmx_pingpong_ctrl
  import bmx_pkg::*;
#(
  parameter int LANES     = 10,
  parameter int PHY_LANES = 4,
  localparam int CW = $clog2(LANES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_i,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          out_ready,
  output logic          out_valid,
  output logic          out_settle,
  output logic          sel,
  output logic          in_fire,
  output bmx_mode_e     wr_mode,
  output logic [CW-1:0] wr_idx,
  output logic [CW-1:0] rd_idx
);
  logic [CW-1:0] wr_cnt, rd_cnt, rd_last_idx;
  logic          wr_full, rd_busy, sel_q, wchg_q, rd_chg_q;
  bmx_mode_e     wmode_q, last_mode_q, rd_mode_q;
  logic          out_fire, wr_last, rd_last, swap;

  assign in_ready    = !wr_full;
  assign in_fire     = in_valid && in_ready;
  assign out_valid   = rd_busy;
  assign out_fire    = out_valid && out_ready;
  assign wr_mode     = (wr_cnt == '0) ? bmx_mode_e'(mode_i) : wmode_q;
  assign rd_last_idx = (rd_mode_q == MODE_XPOSE) ? CW'(PHY_LANES-1) : CW'(LANES-1);
  assign wr_last     = in_fire && (wr_cnt == CW'(LANES-1));
  assign rd_last     = out_fire && (rd_cnt == rd_last_idx);
  assign swap        = (wr_full || wr_last) && (!rd_busy || rd_last);
  assign sel         = sel_q;
  assign wr_idx      = wr_cnt;
  assign rd_idx      = rd_cnt;
  assign out_settle  = rd_chg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_cnt      <= '0;
      rd_cnt      <= '0;
      wr_full     <= 1'b0;
      rd_busy     <= 1'b0;
      sel_q       <= 1'b0;
      wmode_q     <= MODE_STRAIGHT;
      last_mode_q <= MODE_STRAIGHT;
      rd_mode_q   <= MODE_STRAIGHT;
      wchg_q      <= 1'b0;
      rd_chg_q    <= 1'b0;
    end else begin
      if (in_fire) begin
        wr_cnt <= (wr_cnt == CW'(LANES-1)) ? '0 : wr_cnt + 1'b1;
        if (wr_cnt == '0) begin
          wmode_q     <= wr_mode;
          wchg_q      <= (wr_mode != last_mode_q);
          last_mode_q <= wr_mode;
        end
      end
      if (swap) begin
        sel_q     <= !sel_q;
        wr_full   <= 1'b0;
        rd_busy   <= 1'b1;
        rd_cnt    <= '0;
        rd_mode_q <= wmode_q;
        rd_chg_q  <= wchg_q;
      end else begin
        if (wr_last)  wr_full <= 1'b1;
        if (rd_last)  rd_busy <= 1'b0;
        else if (out_fire) rd_cnt <= rd_cnt + 1'b1;
      end
    end
  end

  // R6: a bank swap always hands the reader a freshly filled bank
  a_r6_swap_loads_reader: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q != $past(sel_q)) |-> rd_busy);
  // R7: the output offers a beat only on a slot index inside the period
  a_r7_read_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    rd_busy |-> (rd_cnt <= rd_last_idx));
  // R7: every read period starts at slot zero
  a_r7_read_starts_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_busy) |-> (rd_cnt == '0));
  // R6: the write counter never passes the period length
  a_r6_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt <= CW'(LANES-1));
  // R4: the read-side mode does not move inside a read period
  a_r4_mode_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_busy && $past(rd_busy) && rd_cnt != '0) |-> $stable(rd_mode_q));
endmodule

// File: rtl/lane_bit_matrix.sv
module lane_bit_matrix
  import bmx_pkg::*;
#(
  parameter int LANES     = 10,
  parameter int PHY_LANES = 4,
  parameter int WORD_W    = 16,
  localparam int DW = LANES * WORD_W,
  localparam int CW = $clog2(LANES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          module_type_i,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_settle
);
  logic          sel, in_fire;
  bmx_mode_e     wr_mode;
  logic [CW-1:0] wr_idx, rd_idx;
  logic [DW-1:0] bank_rd [2];

  bmx_pingpong_ctrl #(.LANES(LANES), .PHY_LANES(PHY_LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_i(module_type_i),
    .in_valid(in_valid), .in_ready(in_ready),
    .out_ready(out_ready), .out_valid(out_valid), .out_settle(out_settle),
    .sel(sel), .in_fire(in_fire), .wr_mode(wr_mode),
    .wr_idx(wr_idx), .rd_idx(rd_idx)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    bmx_bank #(.LANES(LANES), .PHY_LANES(PHY_LANES), .WORD_W(WORD_W)) u_bank (
      .clk(clk), .we(in_fire && (sel == 1'(b))), .wmode(wr_mode),
      .widx(wr_idx), .wdata(in_data), .ridx(rd_idx), .rdata(bank_rd[b])
    );
  end

  assign out_data = sel ? bank_rd[0] : bank_rd[1];

  // R8: a stalled output beat is held unchanged
  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_settle)));
  // R6: input is refused only while a finished bank waits for the reader
  a_r6_stall_needs_busy_reader: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid);
endmodule

// File: tb/lane_bit_matrix_tb.sv
module lane_bit_matrix_tb;
  localparam int LANES = 10;
  localparam int PHY = 4;
  localparam int W = 16;
  localparam int DW = LANES * W;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 100000;

  logic clk = 0, rst_n = 0;
  logic module_type_i = 0, in_valid = 0, out_ready = 0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid, out_settle;
  logic [DW-1:0] out_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_bit_matrix #(.LANES(LANES), .PHY_LANES(PHY), .WORD_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .module_type_i(module_type_i),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_settle(out_settle)
  );

  int checks = 0, errors = 0;
  // reference model: expected beats {mode, settle, data}
  logic [DW+1:0] exp_q[$];
  logic [W-1:0] pbuf [LANES][LANES];
  int in_cnt = 0, in_acc = 0;
  logic cur_mode = 0, last_mode = 0;
  logic stall_prev = 0;
  logic [DW:0] stall_val;

  task automatic chk(input bit ok, input string req, input logic [DW:0] act, input logic [DW:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_in(input logic [DW-1:0] d, input logic md);
    logic [DW-1:0] o;
    logic chg;
    if (in_cnt == 0) cur_mode = md;  // R4: sampled on first beat only
    for (int j = 0; j < LANES; j++) pbuf[in_cnt][j] = d[j*W +: W];
    in_cnt++;
    in_acc++;
    if (in_cnt == LANES) begin
      in_cnt = 0;
      chg = (cur_mode != last_mode);
      last_mode = cur_mode;
      if (!cur_mode) begin
        for (int k = 0; k < LANES; k++) begin
          for (int j = 0; j < LANES; j++) o[j*W +: W] = pbuf[k][j];
          exp_q.push_back({cur_mode, chg, o});
        end
      end else begin
        for (int r = 0; r < PHY; r++) begin
          for (int k = 0; k < LANES; k++) o[k*W +: W] = pbuf[k][r];
          exp_q.push_back({cur_mode, chg, o});
        end
      end
    end
  endtask

  task automatic step(input logic v, input logic [DW-1:0] d, input logic md, input logic rdy);
    logic [DW+1:0] e;
    @(negedge clk);
    in_valid = v; in_data = d; module_type_i = md; out_ready = rdy;
    #1;
    if (stall_prev) chk(out_valid && {out_settle, out_data} == stall_val, "R8 hold",
                        {out_settle, out_data}, stall_val);
    stall_prev = out_valid && !out_ready;
    stall_val = {out_settle, out_data};
    if (out_valid && exp_q.size() == 0) chk(0, "R7 valid without period", 1, 0);
    if (out_valid && out_ready && exp_q.size() != 0) begin
      e = exp_q.pop_front();
      chk(out_data == e[DW-1:0], e[DW+1] ? "R3 R4 transpose data" : "R2 R4 R9 straight data",
          {1'b0, out_data}, {1'b0, e[DW-1:0]});
      chk(out_settle == e[DW], "R5 settle flag", {{DW{1'b0}}, out_settle}, {{DW{1'b0}}, e[DW]});
    end
    if (in_valid && in_ready) model_in(in_data, module_type_i);
  endtask

  function automatic logic [DW-1:0] rnd();
    logic [DW-1:0] d = '0;
    for (int i = 0; i < (DW + 31) / 32; i++) d = (d << 32) | DW'($urandom);
    return d;
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic md;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(!out_valid && in_ready, "R1 in reset", {in_ready, out_valid}, 2'b10);
    rst_n = 1;
    @(negedge clk); #1;
    chk(!out_valid && in_ready, "R1 after reset", {in_ready, out_valid}, 2'b10);

    // R7: first straight period, no output until it is complete
    for (int i = 0; i < LANES; i++) begin
      step(1, rnd(), 0, 1);
      chk(!out_valid, "R7 early valid", out_valid, 0);
    end
    step(0, '0, 0, 1);
    chk(out_valid == 1'b0 || exp_q.size() == LANES - 1, "R7 first beat timing", exp_q.size(), LANES - 1);
    for (int i = 0; i < 40 && exp_q.size() != 0; i++) step(0, '0, 0, 1);

    // R6: transpose with output stalled fills both banks
    in_acc = 0;
    for (int i = 0; i < 2 * LANES + 3; i++) step(1, rnd(), 1, 0);
    chk(in_acc == 2 * LANES, "R6 accepted beats", in_acc, 2 * LANES);
    chk(!in_ready, "R6 ready low when full", in_ready, 0);
    for (int i = 0; i < 60 && exp_q.size() != 0; i++) step(0, '0, 1, 1);

    // R4 R5: random traffic with mode flips, some in mid-period
    md = 0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 23 == 0) md = !md;
      step($urandom % 4 != 0, rnd(), md, $urandom % 3 != 0);
    end
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) step(0, '0, md, 1);
    chk(exp_q.size() == 0, "R2 R3 all periods drained", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule